// File: doc/BRIEF.md
# I2C Register-Bank Slave with Auto-Incrementing Pointer

This block is a serial-bus slave that gives a bus master read and write access to a small bank of byte-wide registers. It watches oversampled copies of the SCL and SDA lines. It drives SDA only through an open-drain enable: when the enable is high the line is pulled low. The 7-bit address is a fixed 4-bit prefix followed by three strap pins. After a write address, the first byte is a command byte. That byte loads a 4-bit register pointer and an auto-increment flag. Every later data byte goes to the register the pointer selects.

The bank holds ten registers. Indices 0 and 1 are read-only and return the current levels of 16 external pins. Indices 2 to 9 are writable settings: two period values, two duty values and four output-mode bytes. The settings are presented as one flat vector to a waveform generator that sits beside this block. A master normally sends a write address and a command byte, then either streams data bytes or issues a repeated START with a read address to fetch data from the pointed register.

The protocol is a state machine with ten states:
- `S_IDLE`: waiting for a START.
- `S_ADDR`: shifting in the address byte.
- `S_ADDR_ACK`: acknowledging a matching address.
- `S_CMD`: shifting in the command byte.
- `S_CMD_ACK`: acknowledging the command byte.
- `S_WR`: shifting in a data byte.
- `S_WR_ACK`: acknowledging a data byte.
- `S_RD`: shifting a byte out.
- `S_RD_ACK`: sampling the master's acknowledge.
- `S_IGNORE`: bus released until the next START or STOP.

The transitions are:
- START from any state goes to `S_ADDR`, and STOP from any state goes to `S_IDLE`.
- `S_ADDR` goes to `S_ADDR_ACK` on a match, or to `S_IGNORE` on a mismatch, at the SCL fall after the eighth bit.
- `S_ADDR_ACK` goes to `S_RD` for a read address, or to `S_CMD` for a write address.
- `S_CMD` goes to `S_CMD_ACK`, and `S_CMD_ACK` goes to `S_WR`.
- `S_WR` goes to `S_WR_ACK`, and `S_WR_ACK` goes back to `S_WR`.
- `S_RD` goes to `S_RD_ACK` after the eighth bit.
- `S_RD_ACK` goes to `S_RD` when the master acknowledged, or to `S_IGNORE` when it did not.

Top module: `ir_i2c_regbank`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1100 followed by `strap_i[2:0]`. Bit 0 of the address byte selects a read when 1 and a write when 0.
- R2: On an address that does not match, the slave keeps SDA released. It acknowledges nothing more until the next START.
- R3: The first byte after a write address is the command byte and is acknowledged. Its bit 4 is the auto-increment flag and bits 3:0 are the register index. Bits 7:5 are ignored.
- R4: Every data byte after the command byte is acknowledged. For indices 2 to 9, the byte is stored in that register, and byte k of `regs_o` holds register k+2.
- R5: Writes to indices 0, 1 and 10 to 15 are acknowledged and change no register.
- R6: Reading index 0 returns `pin_i[7:0]` and index 1 returns `pin_i[15:8]`. The pins are captured at the SCL fall that ends the acknowledge bit before that byte. Indices 10 to 15 read as 00h.
- R7: With the auto-increment flag set, the pointer advances after every byte written or read. It wraps from 9 to 0 and from 15 to 0. With the flag clear, the pointer stays fixed.
- R8: During a read, SDA is released for the acknowledge bit. A master acknowledge starts the next byte. A missing acknowledge leaves SDA released until the next START or STOP.
- R9: A repeated START goes back to address matching and keeps the register pointer, so a write of the command byte followed by a read address reads the pointed register.
- R10: While `rst_n` is low, the registers hold these values: indices 2 and 4 hold FFh, 3 and 5 hold 80h, 6 to 9 hold 55h. The pointer and flag are 0 and SDA is released.
- R11: A STOP in the middle of a byte abandons that byte without writing it and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1 |
| strap_i | input | 3 | Low three address bits |
| pin_i | input | 16 | External pin levels for the read-only registers |
| regs_o | output | 64 | Writable registers 2..9, byte k = register k+2 |

## Verification
A table of single-register write-then-read transactions covers the writable registers, both input registers and an index above the map. It separates true storage from acknowledged-but-inert writes and from the zero readback of unmapped indices. Auto-increment bursts start at index 2, at index 8 and at index 15. These show the two wrap points apart, and a burst with the flag clear shows that the pointer does not move. Directed cases cover these behaviours:
- A wrong strap address.
- A read that the master does not acknowledge.
- A pin change between two bytes of one read, which shows when the pins are captured.
- A STOP in the middle of a byte.
- Reset in the middle of the run.

// File: rtl/ir_pkg.sv
package ir_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_ACK,
        S_IGNORE
    } ir_state_e;

    // Default contents of the settings registers by index
    function automatic logic [7:0] reg_reset_val(input int unsigned idx);
        logic [7:0] v;
        case (idx)
            2, 4:    v = 8'hFF;
            3, 5:    v = 8'h80;
            default: v = 8'h55;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ir_bus_sampler.sv
module ir_bus_sampler #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl    = scl_sh[STAGES-1];
    assign sda_lvl    = sda_sh[STAGES-1];
    assign scl_rise   = scl_lvl & ~scl_d;
    assign scl_fall   = ~scl_lvl & scl_d;
    assign start_seen = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_seen  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/ir_reg_bank.sv
module ir_reg_bank #(
    parameter int unsigned NUM_REGS = 10,
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned PIN_W    = 16,
    localparam int unsigned IN_REGS = PIN_W / 8,
    localparam int unsigned NUM_RW  = NUM_REGS - IN_REGS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [7:0]          wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic [PIN_W-1:0]    pin_in,
    output logic [7:0]          rd_data,
    output logic [8*NUM_RW-1:0] regs_flat
);
    import ir_pkg::*;

    for (genvar k = 0; k < NUM_RW; k++) begin : g_reg
        localparam logic [7:0] RV = reg_reset_val(k + IN_REGS);
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= RV;
            else if (wr_en && wr_idx == IDX_W'(k + IN_REGS))
                q <= wr_data;
        end
        assign regs_flat[k*8 +: 8] = q;
    end

    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < int'(IN_REGS); k++)
            if (rd_idx == IDX_W'(k)) rd_data = pin_in[k*8 +: 8];
        for (int k = 0; k < int'(NUM_RW); k++)
            if (rd_idx == IDX_W'(k + IN_REGS)) rd_data = regs_flat[k*8 +: 8];
    end

    // Writes outside the settings range leave every stored byte unchanged
    assert_inert_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx < IDX_W'(IN_REGS) || wr_idx >= IDX_W'(NUM_REGS)))
        |=> $stable(regs_flat));

endmodule

// File: rtl/ir_i2c_regbank.sv
module ir_i2c_regbank #(
    parameter logic [3:0]  ADDR_PREFIX = 4'b1100,
    parameter int unsigned NUM_REGS    = 10,
    parameter int unsigned PIN_W       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDX_W      = 4,
    localparam int unsigned AI_BIT     = IDX_W,
    localparam int unsigned NUM_RW     = NUM_REGS - PIN_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [2:0]          strap_i,
    input  logic [PIN_W-1:0]    pin_i,
    output logic [8*NUM_RW-1:0] regs_o
);
    import ir_pkg::*;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;

    ir_bus_sampler #(.STAGES(SYNC_STAGES)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl    (scl_lvl),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    ir_state_e        st, st_nx;
    logic [3:0]       cnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic [IDX_W-1:0] ptr;
    logic             ai;
    logic             rd_mode;
    logic             m_ack;
    logic [7:0]       rd_data;
    logic             wr_en;
    logic             adv;
    logic             addr_hit;
    logic             byte_in_done;
    logic             byte_out_done;

    assign addr_hit      = (rx_sh[7:1] == {ADDR_PREFIX, strap_i});
    assign byte_in_done  = scl_fall && (cnt == 4'd8);
    assign byte_out_done = scl_fall && (cnt == 4'd7);
    assign wr_en         = (st == S_WR) && byte_in_done && !start_seen && !stop_seen;
    assign adv           = ai && !start_seen && !stop_seen &&
                           (((st == S_WR) && byte_in_done) || ((st == S_RD) && byte_out_done));

    function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(NUM_REGS - 1)) ? '0 : p + 1'b1;
    endfunction

    ir_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .PIN_W(PIN_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (ptr),
        .wr_data   (rx_sh),
        .rd_idx    (ptr),
        .pin_in    (pin_i),
        .rd_data   (rd_data),
        .regs_flat (regs_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        if (stop_seen) begin
            st_nx = S_IDLE;
        end else if (start_seen) begin
            st_nx = S_ADDR;
        end else begin
            unique case (st)
                S_IDLE:     st_nx = S_IDLE;
                S_ADDR:     if (byte_in_done) st_nx = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK: if (scl_fall) st_nx = rd_mode ? S_RD : S_CMD;
                S_CMD:      if (byte_in_done) st_nx = S_CMD_ACK;
                S_CMD_ACK:  if (scl_fall) st_nx = S_WR;
                S_WR:       if (byte_in_done) st_nx = S_WR_ACK;
                S_WR_ACK:   if (scl_fall) st_nx = S_WR;
                S_RD:       if (byte_out_done) st_nx = S_RD_ACK;
                S_RD_ACK:   if (scl_fall) st_nx = m_ack ? S_RD : S_IGNORE;
                S_IGNORE:   st_nx = S_IGNORE;
                default:    st_nx = S_IDLE;
            endcase
        end
    end

    // Datapath: bit counter, shifters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr     <= '0;
            ai      <= 1'b0;
            rd_mode <= 1'b0;
            m_ack   <= 1'b0;
        end else if (start_seen || stop_seen) begin
            cnt <= '0;
        end else begin
            unique case (st)
                S_ADDR, S_CMD, S_WR: begin
                    if (scl_rise) begin
                        rx_sh <= {rx_sh[6:0], sda_lvl};
                        cnt   <= cnt + 4'd1;
                    end
                    if (byte_in_done) begin
                        if (st == S_ADDR) rd_mode <= rx_sh[0];
                        if (st == S_CMD) begin
                            ptr <= rx_sh[IDX_W-1:0];
                            ai  <= rx_sh[AI_BIT];
                        end
                        if (adv) ptr <= step_ptr(ptr);
                    end
                end
                S_ADDR_ACK, S_CMD_ACK, S_WR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (st == S_ADDR_ACK && rd_mode) tx_sh <= rd_data;
                    end
                end
                S_RD: begin
                    if (scl_fall) begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        cnt   <= cnt + 4'd1;
                        if (adv) ptr <= step_ptr(ptr);
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) m_ack <= ~sda_lvl;
                    if (scl_fall && m_ack) begin
                        tx_sh <= rd_data;
                        cnt   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output logic
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (st)
            S_ADDR_ACK, S_CMD_ACK, S_WR_ACK: sda_oe_o = 1'b1;
            S_RD:                            sda_oe_o = ~tx_sh[7];
            default:                         sda_oe_o = 1'b0;
        endcase
    end

    // A non-matching address sends the slave to the ignore state
    assert_mismatch_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ADDR && byte_in_done && !addr_hit && !start_seen && !stop_seen)
        |=> (st == S_IGNORE && !sda_oe_o));

    // Pointer wraps to zero after the last mapped register
    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == IDX_W'(NUM_REGS - 1)) |=> (ptr == '0));

    // A missing master acknowledge releases the line
    assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RD_ACK && scl_fall && !m_ack && !start_seen && !stop_seen)
        |=> (st == S_IGNORE && !sda_oe_o));

    // The drive on SDA only moves while SCL is low
    assert_sda_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o))
        |-> (!scl_lvl || $past(start_seen) || $past(stop_seen)));

    // A START keeps the stored pointer
    assert_start_keeps_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> (ptr == $past(ptr)));

endmodule

// File: tb/sim_ir_i2c_regbank.sv
module sim_ir_i2c_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int PH         = 8;
    localparam int MAX_CYC    = 150000;
    localparam logic [63:0] RST_REGS = 64'h55555555_80FF80FF;

    typedef struct packed {
        logic [3:0] idx;
        logic [7:0] wv;
        logic [7:0] ev;
    } vec_t;

    // pin_i = 16'hA53C while the table runs
    localparam vec_t TBL [10] = '{
        '{4'd2,  8'h2B, 8'h2B},
        '{4'd3,  8'h40, 8'h40},
        '{4'd4,  8'h0A, 8'h0A},
        '{4'd5,  8'hC0, 8'hC0},
        '{4'd6,  8'h00, 8'h00},
        '{4'd7,  8'hAA, 8'hAA},
        '{4'd0,  8'hFF, 8'h3C},
        '{4'd1,  8'h00, 8'hA5},
        '{4'd12, 8'h77, 8'h00},
        '{4'd9,  8'h69, 8'h69}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic [15:0] pin = 16'hA53C;
    logic        sda_oe;
    logic [63:0] regs;
    logic        sda_bus;
    int          n_chk = 0;
    int          n_bad = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_i2c_regbank u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .strap_i  (strap),
        .pin_i    (pin),
        .regs_o   (regs)
    );

    task automatic w(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; w(PH);
        scl_m = 1'b1; w(PH);
        sda_m = 1'b0; w(PH);
        scl_m = 1'b0; w(PH);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; w(PH);
        scl_m = 1'b1; w(PH);
        sda_m = 1'b1; w(PH);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    w(PH);
        scl_m = 1'b1; w(PH);
        scl_m = 1'b0; w(PH);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; w(PH);
        scl_m = 1'b1; w(PH/2);
        b = sda_bus;  w(PH/2);
        scl_m = 1'b0; w(PH);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            d[i] = x;
        end
        put_bit(~give_ack);
    endtask

    function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rw);
        return {4'b1100, s, rw};
    endfunction

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] d, input string req);
        logic a;
        bus_start;
        send_byte(addr_byte(strap, 1'b0), a); check("R1 address ack", a, 1);
        send_byte(cmd, a);                    check("R3 command ack", a, 1);
        send_byte(d, a);                      check(req, a, 1);
        bus_stop;
    endtask

    task automatic do_read(input logic [7:0] cmd, output logic [7:0] d);
        logic a;
        bus_start;
        send_byte(addr_byte(strap, 1'b0), a); check("R1 address ack", a, 1);
        send_byte(cmd, a);                    check("R3 command ack", a, 1);
        bus_start;
        send_byte(addr_byte(strap, 1'b1), a); check("R9 read address after repeated start", a, 1);
        recv_byte(d, 1'b0);
        bus_stop;
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", MAX_CYC);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic       a;
        logic [7:0] burst [11];

        w(5);
        check("R10 regs during reset", regs, RST_REGS);
        check("R10 sda released in reset", sda_oe, 1'b0);
        rst_n = 1'b1;
        w(5);
        check("R10 regs after reset", regs, RST_REGS);

        // Table of single-register write then read-back
        for (int i = 0; i < 10; i++) begin
            string rq;
            rq = (TBL[i].idx < 4'd2 || TBL[i].idx > 4'd9) ? "R5 inert write" : "R4 stored write";
            do_write({4'b0000, TBL[i].idx}, TBL[i].wv, rq);
            do_read({4'b0000, TBL[i].idx}, d);
            check((TBL[i].idx < 4'd2 || TBL[i].idx > 4'd9) ? "R6 readback" : "R4 readback",
                  d, TBL[i].ev);
        end
        check("R4 register port after table", regs, 64'h6955AA00_C00A402B);

        // R7: burst write from index 2 wraps through 9 -> 0; R3: upper command bits ignored
        burst = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAB, 8'h5A};
        bus_start;
        send_byte(addr_byte(strap, 1'b0), a); check("R1 address ack", a, 1);
        send_byte(8'hF2, a);                  check("R3 command ack with high bits", a, 1);
        for (int i = 0; i < 11; i++) begin
            send_byte(burst[i], a);
            check("R4 burst byte ack", a, 1);
        end
        bus_stop;
        check("R7 burst wrap 9->0 and R5 inputs inert", regs, 64'h88776655_4433225A);

        // R7/R6: burst read from 8 wraps into the input registers
        bus_start;
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h18, a);
        bus_start;
        send_byte(addr_byte(strap, 1'b1), a); check("R1 read address ack", a, 1);
        recv_byte(d, 1'b1); check("R7 burst read idx8", d, 8'h77);
        recv_byte(d, 1'b1); check("R7 burst read idx9", d, 8'h88);
        recv_byte(d, 1'b1); check("R6 burst read idx0", d, 8'h3C);
        recv_byte(d, 1'b1); check("R6 burst read idx1", d, 8'hA5);
        recv_byte(d, 1'b0); check("R7 burst read idx2", d, 8'h5A);
        bus_stop;

        // R7: flag clear keeps the pointer fixed
        bus_start;
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h05, a);
        bus_start;
        send_byte(addr_byte(strap, 1'b1), a);
        recv_byte(d, 1'b1); check("R7 fixed pointer byte 1", d, 8'h44);
        recv_byte(d, 1'b0); check("R7 fixed pointer byte 2", d, 8'h44);
        bus_stop;

        // R7: burst from 15 wraps to 0
        bus_start;
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h1F, a);
        send_byte(8'hE1, a); send_byte(8'hE2, a); send_byte(8'hE3, a); send_byte(8'hE4, a);
        bus_stop;
        check("R7 wrap 15->0 reaches idx2", regs, 64'h88776655_443322E4);
        do_read(8'h0F, d);
        check("R6 unmapped index reads zero", d, 8'h00);

        // R2: wrong strap address
        bus_start;
        send_byte(addr_byte(3'b001, 1'b0), a); check("R2 mismatched address nack", a, 0);
        send_byte(8'h02, a);                   check("R2 no ack after mismatch", a, 0);
        send_byte(8'h00, a);                   check("R2 no ack on data", a, 0);
        bus_stop;
        check("R2 registers untouched", regs, 64'h88776655_443322E4);

        // R8: master NACK releases the bus
        bus_start;
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h16, a);
        bus_start;
        send_byte(addr_byte(strap, 1'b1), a);
        recv_byte(d, 1'b0); check("R8 byte before nack", d, 8'h55);
        recv_byte(d, 1'b0); check("R8 line released after nack", d, 8'hFF);
        bus_stop;
        do_read(8'h07, d);
        check("R11 new transaction after stop", d, 8'h66);

        // R6: pin capture at each acknowledge fall
        pin = 16'h1111;
        bus_start;
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h10, a);
        bus_start;
        send_byte(addr_byte(strap, 1'b1), a);
        pin = 16'h2222;
        w(3);
        pin = 16'h3322;
        recv_byte(d, 1'b1); check("R6 first byte captured at address ack", d, 8'h11);
        recv_byte(d, 1'b0); check("R6 second byte captured at master ack", d, 8'h33);
        bus_stop;

        // R11: STOP in the middle of a byte
        bus_start;
        send_byte(addr_byte(strap, 1'b0), a);
        send_byte(8'h03, a);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop;
        check("R11 partial byte discarded", regs, 64'h88776655_443322E4);
        do_read(8'h03, d);
        check("R11 readback after abort", d, 8'h22);

        // R10: reset mid-run
        rst_n = 1'b0;
        w(3);
        check("R10 regs held in reset", regs, RST_REGS);
        rst_n = 1'b1;
        w(5);
        bus_start;
        send_byte(addr_byte(strap, 1'b1), a); check("R10 read address ack after reset", a, 1);
        recv_byte(d, 1'b0); check("R10 pointer reset to index 0", d, 8'h22);
        bus_stop;
        do_read(8'h02, d);
        check("R10 default of index 2", d, 8'hFF);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule